// File: doc/BRIEF.md
# Blanking-Level Video Clamp

This block sits on the digitized composite video path behind the A/D converter. It receives one 8-bit sample each time the sample strobe is high, which is every other clock. A separate window input is raised across the flat part of the blanking interval on each line. The block averages the samples taken inside that window and smooths the result from line to line. It then shifts every sample by a fixed offset so that the blanking level always comes out at the same code.

That code is 3Ch for the 525-line standard and 40h for the 625-line standard, selected by `pal_sel`. With the correction switched off, samples go through unchanged. The block also outputs the integer part of its smoothed level, so the rest of the chip can monitor the clamp.

The smoothed level changes only when a window closes. The offset therefore stays the same across the whole visible part of a line, and small line-to-line noise in the blanking level does not show up as horizontal streaks.

Top module: `bpc_clamp_top`

## Requirements
- R1: With `clamp_en` high, a strobed sample p gives `out_data` = p − L + T one clock later. L is `level_out` at the sampling edge and T is the blanking target. A sample equal to L therefore comes out as T.
- R2: With `clamp_en` low, a strobed sample appears unchanged on `out_data` one clock later.
- R3: The target T is 3Ch when `pal_sel` is 0 and 40h when `pal_sel` is 1.
- R4: The corrected value saturates. Results below 0 give 00h, and results above 255 give FFh.
- R5: The line measurement A is the sum of the first 16 strobed samples taken while `bp_gate` is high, shifted right by 4. Any further gated samples in the same window have no effect.
- R6: A window that closes with fewer than 16 gated samples leaves the smoothed level unchanged.
- R7: The smoothed level F is a 12-bit value with 4 fraction bits. When a window closes, it becomes F + floor((A·16 − F)/8). The new value is visible on `level_out` (F >> 4) from the second rising edge after `bp_gate` is first sampled low. At no other time does F change.
- R8: While `rst_n` is low (synchronous reset), F is loaded with T·16, so `level_out` = T. `out_valid` is also cleared.
- R9: `out_valid` is the sample strobe delayed by one clock. `out_data` holds its value on cycles without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (twice the sample rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_stb | input | 1 | Sample strobe, high on cycles that carry a sample |
| pix_data | input | 8 | Digitized composite sample |
| bp_gate | input | 1 | High across the blanking measurement window |
| pal_sel | input | 1 | 0: target 3Ch, 1: target 40h |
| clamp_en | input | 1 | 1: apply correction, 0: pass through |
| out_valid | output | 1 | Strobe for `out_data` |
| out_data | output | 8 | Corrected (or passed) sample |
| level_out | output | 8 | Integer part of the smoothed blanking level |

## Verification
The assertions assume that `bp_gate` and `pix_stb` are synchronous to `clk`. They also assume that each window is separated from the next by at least two clocks with the gate low, so that a close and its filter update cannot overlap with the next close. The stimulus raises the strobe on alternate cycles only. It changes inputs on the falling edge and keeps the gate low for several clocks between windows. The bench sweeps all 256 sample values against several smoothed levels under both standards. These levels are chosen so that both saturation limits are reached.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } vid_std_e;

    localparam logic [7:0] BLANK_525 = 8'h3C;
    localparam logic [7:0] BLANK_625 = 8'h40;

    function automatic logic [7:0] blank_code(input vid_std_e s);
        return (s == STD_625) ? BLANK_625 : BLANK_525;
    endfunction

endpackage

// File: rtl/bpc_level_meas.sv
module bpc_level_meas #(
    parameter int DW       = 8,
    parameter int AVG_LOG2 = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_stb,
    input  logic [DW-1:0] pix_data,
    input  logic          bp_gate,
    output logic          line_done,
    output logic [DW-1:0] line_avg
);
    localparam int NS = 1 << AVG_LOG2;
    localparam int CW = AVG_LOG2 + 1;
    localparam int AW = DW + AVG_LOG2;

    typedef struct packed {
        logic          gate_seen;
        logic [CW-1:0] cnt;
        logic [AW-1:0] acc;
        logic          done;
        logic [DW-1:0] avg;
    } meas_t;

    meas_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.gate_seen = bp_gate;
        if (bp_gate && pix_stb && (st_q.cnt < CW'(NS))) begin
            st_d.acc = st_q.acc + {{AVG_LOG2{1'b0}}, pix_data};
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (st_q.gate_seen && !bp_gate) begin
            st_d.done = (st_q.cnt == CW'(NS));
            if (st_q.cnt == CW'(NS)) begin
                st_d.avg = st_q.acc[AW-1:AVG_LOG2];
            end
            st_d.acc = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_done = st_q.done;
    assign line_avg  = st_q.avg;

    // R7: a completed window raises a single-cycle update pulse
    p_done_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

    // R6: an update is only issued right after the window has closed
    p_done_after_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (!$past(bp_gate) && $past(bp_gate, 2)));

    // R5: the average only moves together with an update pulse
    p_avg_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !line_done |-> $stable(line_avg) || $past(!rst_n));

endmodule

// File: rtl/bpc_line_filter.sv
module bpc_line_filter #(
    parameter int DW    = 8,
    parameter int FRAC  = 4,
    parameter int SHIFT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] target,
    input  logic          upd,
    input  logic [DW-1:0] line_avg,
    output logic [DW-1:0] level_int
);
    localparam int LW = DW + FRAC;

    typedef struct packed {
        logic [LW-1:0] lvl;
    } filt_t;

    filt_t st_d, st_q;

    logic        [LW-1:0] new_fx;
    logic signed [LW:0]   diff_s;
    logic signed [LW:0]   step_s;
    logic signed [LW:0]   sum_s;

    always_comb begin
        new_fx = {line_avg, {FRAC{1'b0}}};
        diff_s = $signed({1'b0, new_fx}) - $signed({1'b0, st_q.lvl});
        step_s = diff_s >>> SHIFT;
        sum_s  = $signed({1'b0, st_q.lvl}) + step_s;
        st_d   = st_q;
        if (upd) begin
            st_d.lvl = sum_s[LW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lvl <= {target, {FRAC{1'b0}}};
        end else begin
            st_q <= st_d;
        end
    end

    logic [LW-1:0] lvl_q;
    assign lvl_q     = st_q.lvl;
    assign level_int = st_q.lvl[LW-1:FRAC];

    // R7: level is frozen between window closes
    p_hold_between_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(lvl_q));

    // R7: an update lands between the old level and the new measurement
    p_no_overshoot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (($past(new_fx) >= $past(lvl_q)) ?
                 ((lvl_q >= $past(lvl_q)) && (lvl_q <= $past(new_fx))) :
                 ((lvl_q <= $past(lvl_q)) && (lvl_q >= $past(new_fx)))));

endmodule

// File: rtl/bpc_offset_apply.sv
module bpc_offset_apply #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_stb,
    input  logic [DW-1:0] pix_data,
    input  logic          clamp_en,
    input  logic [DW-1:0] target,
    input  logic [DW-1:0] level_int,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] dat;
    } outp_t;

    outp_t st_d, st_q;

    logic signed [DW+1:0] corr_s;
    logic        [DW-1:0] sat_v;

    always_comb begin
        corr_s = $signed({2'b00, pix_data}) + $signed({2'b00, target})
               - $signed({2'b00, level_int});
        if (corr_s < 0) begin
            sat_v = '0;
        end else if (corr_s > $signed({2'b00, {DW{1'b1}}})) begin
            sat_v = '1;
        end else begin
            sat_v = corr_s[DW-1:0];
        end
        st_d     = st_q;
        st_d.vld = pix_stb;
        if (pix_stb) begin
            st_d.dat = clamp_en ? sat_v : pix_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;

    // R2: bypass passes the sample unchanged
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && !clamp_en) |=> (out_data == $past(pix_data)));

    // R1: a sample sitting at the measured level comes out at the target
    p_blank_to_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && clamp_en && (pix_data == level_int)) |=> (out_data == $past(target)));

    // R9: strobe follows input by one clock
    p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |=> out_valid);
    p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_stb |=> !out_valid);

    // R9: data held without a strobe
    p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_stb |=> $stable(out_data));

endmodule

// File: rtl/bpc_clamp_top.sv
module bpc_clamp_top #(
    parameter int DW       = 8,
    parameter int AVG_LOG2 = 4,
    parameter int FRAC     = 4,
    parameter int SHIFT    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_stb,
    input  logic [DW-1:0] pix_data,
    input  logic          bp_gate,
    input  logic          pal_sel,
    input  logic          clamp_en,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic [DW-1:0] level_out
);
    import bpc_pkg::*;

    vid_std_e      std_sel;
    logic [DW-1:0] target;
    logic          line_done;
    logic [DW-1:0] line_avg;
    logic [DW-1:0] level_int;

    assign std_sel = pal_sel ? STD_625 : STD_525;
    assign target  = DW'(blank_code(std_sel));

    bpc_level_meas #(.DW(DW), .AVG_LOG2(AVG_LOG2)) u_meas (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_stb   (pix_stb),
        .pix_data  (pix_data),
        .bp_gate   (bp_gate),
        .line_done (line_done),
        .line_avg  (line_avg)
    );

    bpc_line_filter #(.DW(DW), .FRAC(FRAC), .SHIFT(SHIFT)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .target    (target),
        .upd       (line_done),
        .line_avg  (line_avg),
        .level_int (level_int)
    );

    bpc_offset_apply #(.DW(DW)) u_apply (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_stb   (pix_stb),
        .pix_data  (pix_data),
        .clamp_en  (clamp_en),
        .target    (target),
        .level_int (level_int),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign level_out = level_int;

endmodule

// File: tb/sim_bpc_clamp_top.sv
module sim_bpc_clamp_top;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_stb = 1'b0;
    logic [7:0] pix_data = 8'h00;
    logic       bp_gate = 1'b0;
    logic       pal_sel = 1'b0;
    logic       clamp_en = 1'b1;
    logic       out_valid;
    logic [7:0] out_data;
    logic [7:0] level_out;

    int n_chk = 0;
    int n_bad = 0;
    int f_model = 0;

    always #(CLK_NS/2) clk = ~clk;

    bpc_clamp_top u0 (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .pix_data(pix_data),
        .bp_gate(bp_gate), .pal_sel(pal_sel), .clamp_en(clamp_en),
        .out_valid(out_valid), .out_data(out_data), .level_out(level_out)
    );

    function automatic int tgt();
        return pal_sel ? 32'h40 : 32'h3C; // R3
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic put_pix(input int d, input logic g);
        int raw;
        int exp;
        @(negedge clk);
        pix_stb  = 1'b1;
        pix_data = d[7:0];
        bp_gate  = g;
        raw = d - (f_model >> 4) + tgt();
        @(negedge clk);
        chk("R9 valid", int'(out_valid), 1);
        if (!clamp_en) begin
            chk("R2 bypass", int'(out_data), d);
        end else if (raw < 0) begin
            chk("R4 low sat", int'(out_data), 0);
        end else if (raw > 255) begin
            chk("R4 high sat", int'(out_data), 255);
        end else begin
            exp = raw;
            chk("R1 offset", int'(out_data), exp);
        end
        pix_stb = 1'b0;
        @(negedge clk);
        chk("R9 hold", int'(out_data), (!clamp_en) ? d :
            ((raw < 0) ? 0 : ((raw > 255) ? 255 : raw)));
        chk("R9 idle", int'(out_valid), 0);
    endtask

    task automatic window(input int n, input int base, input int extra);
        int sum = 0;
        for (int i = 0; i < n; i++) begin
            int v;
            v = (i < 16) ? (base + (i % 3) - 1) : extra;
            if (i < 16) sum += v;
            put_pix(v, 1'b1);
        end
        @(negedge clk);
        bp_gate = 1'b0;
        repeat (3) @(negedge clk);
        if (n >= 16) begin
            int a;
            int d;
            a = sum >> 4;
            d = a * 16 - f_model;
            f_model = f_model + (d >>> 3);
            chk(n > 16 ? "R5 extra ignored" : "R7 filter step", int'(level_out), f_model >> 4);
        end else begin
            chk("R6 short window", int'(level_out), f_model >> 4);
        end
    endtask

    task automatic sweep(input logic en);
        clamp_en = en;
        for (int p = 0; p < 256; p++) begin
            put_pix(p, 1'b0);
        end
        clamp_en = 1'b1;
    endtask

    task automatic do_reset(input logic pal);
        @(negedge clk);
        rst_n   = 1'b0;
        pal_sel = pal;
        pix_stb = 1'b0;
        bp_gate = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        f_model = tgt() * 16;
        @(negedge clk);
        chk("R8 level reset", int'(level_out), tgt());
        chk("R8 valid reset", int'(out_valid), 0);
        chk("R3 target code", int'(level_out), pal ? 32'h40 : 32'h3C);
    endtask

    initial begin
        for (int s = 0; s < 2; s++) begin
            do_reset(s[0]);
            sweep(1'b1);
            for (int k = 0; k < 6; k++) window(16, 8'h50, 0);
            sweep(1'b1);
            window(24, 8'h20, 8'hFF);
            window(9, 8'hF0, 0);
            sweep(1'b0);
            for (int k = 0; k < 20; k++) window(16, 8'h90, 0);
            sweep(1'b1);
            for (int k = 0; k < 30; k++) window(16, 8'h05, 0);
            sweep(1'b1);
            window(20, 8'hC0, 8'h00);
            sweep(1'b1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 act=timeout exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule